// File: doc/BRIEF.md
# DRAM Strobe Sequencer for Single-Address DMA

This block drives the row strobe, column strobe and write enable for DRAM accesses issued by a DMA engine in single-address mode. It accepts one request at a time (direction, chip-select space, row). It signals completion with a one-cycle done pulse. Between accesses the row strobe stays low on the last opened row. A later access to that same row and space then skips the precharge and row-to-column delay and starts its column strobe at once.

A small configuration word sets the timing. It holds a read wait count that stretches each read's column strobe, a column width select for writes, and an enable for one idle cycle. When enabled, that idle cycle goes ahead of a same-row burst that follows a switch into the DRAM space from another space, or a read-to-write turn within the same DRAM space. When the EDO input is high, the wait count and the write width are treated as zero. Requests to a space that is not one of the two DRAM spaces touch none of the DRAM strobes. A configuration write that arrives mid-access is held and applied when that access ends.

Top module: `dram_wait_seq`

## Requirements
- R1: After reset rasN, casN and weN are high, doneP is low, reqReady is high, and cfgRdData reads 0x1E0. The configuration word has the read wait count in bits 8:5, the idle enable in bit 4, the write width select in bit 3, and bits 2:0 fixed at zero.
- R2: A DRAM read holds casN low for 1 + W consecutive cycles, where W is the wait count, and keeps weN high.
- R3: A DRAM write holds casN low for 1 cycle when the width select is 0 and for 2 cycles when it is 1, with weN low in exactly those cycles.
- R4: While edoMode is high, reads hold casN low for 1 cycle and writes for 1 cycle, whatever the wait count and the width select.
- R5: A DRAM access that misses the open row or space raises rasN for one precharge cycle, then lowers rasN for one cycle before casN falls: casN goes low in the third cycle after acceptance.
- R6: A DRAM access that hits the open row and space keeps rasN low throughout, and casN goes low in the first cycle after acceptance when no idle cycle applies.
- R7: With the idle enable set, a row hit gets exactly one extra cycle before casN falls when its space differs from the previous access's space, or when the previous access was a read and this one is a write. Otherwise, and always with the enable clear, no idle cycle is added.
- R8: An access to a space other than the two DRAM spaces (4 and 5 by default) leaves casN and weN high and rasN unchanged, and completes with doneP in the second cycle after acceptance.
- R9: doneP is high for exactly one cycle, the cycle after the last casN-low cycle. reqReady is low from acceptance through that done cycle.
- R10: Writes to configuration bits 2:0 have no effect: they always read back as zero.
- R11: A configuration write made during an access leaves cfgRdData and that access's timing unchanged, and is visible in the done cycle and used by the next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 9 | Configuration write word |
| cfgRdData | output | 9 | Configuration word in effect |
| edoMode | input | 1 | EDO operation: forces zero waits and single-cycle write strobe |
| reqValid | input | 1 | Access request valid |
| reqWrite | input | 1 | Request direction, 1 for write |
| reqSpace | input | 3 | Chip-select space of the request |
| reqRow | input | 8 | Row address of the request |
| reqReady | output | 1 | Request accepted in this cycle when reqValid is high |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| doneP | output | 1 | One-cycle access-complete pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit row, a 3-bit space with DRAM spaces 4 and 5, and a 4-bit wait field. The 4-bit wait field lets a read reach the full 16-cycle column strobe at the largest count. The small row width lets a short directed sequence produce hits, row misses, cross-space misses, space switches and read-to-write turns. Each access is measured at the pins: the cycles to the first column strobe, the column strobe length, whether the row strobe rose, and whether write enable fell.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a request or in the done cycle
    ST_PRE,    // row strobe high for precharge
    ST_RCD,    // row strobe low, column strobe not yet
    ST_GAP,    // inserted idle cycle before a same-row burst
    ST_CAS,    // column strobe low
    ST_FOR     // access to a non-DRAM space
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;      // request accepted: record space and direction
    logic missTake;  // accepted DRAM miss: close row, capture new row/space
    logic rowUp;     // precharge over: open the captured row
    logic finish;    // access ends at this edge: apply deferred config
    logic busy;      // an access is in progress
  } seqStrobe_t;

endpackage

// File: rtl/dram_seq_dp.sv
module dram_seq_dp
  import dram_seq_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int SPACE_W = 3,
  parameter int WAIT_W  = 4,
  parameter int DRAM_A  = 4,
  parameter int DRAM_B  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [WAIT_W+4:0]   cfgWrData,
  output logic [WAIT_W+4:0]   cfgRdData,
  input  logic                edoMode,
  input  logic                reqWrite,
  input  logic [SPACE_W-1:0]  reqSpace,
  input  logic [ROW_W-1:0]    reqRow,
  input  seqStrobe_t          strobes,
  output logic                isDram,
  output logic                rowHit,
  output logic                idleNeed,
  output logic [WAIT_W-1:0]   waitEff,
  output logic                wideEff,
  output logic                rowOpen
);

  localparam int CFG_W    = WAIT_W + 5;
  localparam int WAIT_LSB = 5;
  localparam int IDLE_BIT = 4;
  localparam int WIDE_BIT = 3;
  localparam logic [CFG_W-1:0] LOW_MASK  = {{(CFG_W-3){1'b0}}, 3'b111};
  localparam logic [CFG_W-1:0] CFG_RESET = {{WAIT_W{1'b1}}, 5'b00000};
  localparam logic [SPACE_W-1:0] SPACE_A = SPACE_W'(DRAM_A);
  localparam logic [SPACE_W-1:0] SPACE_B = SPACE_W'(DRAM_B);

  logic [CFG_W-1:0]   cfgReg;
  logic [CFG_W-1:0]   pendData;
  logic               pendValid;
  logic [CFG_W-1:0]   wrMasked;
  logic [ROW_W-1:0]   openRow;
  logic [SPACE_W-1:0] openSpace;
  logic [SPACE_W-1:0] lastSpace;
  logic               lastWrite;

  assign wrMasked  = cfgWrData & ~LOW_MASK;
  assign cfgRdData = cfgReg;

  // Configuration word with deferral while busy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= CFG_RESET;
      pendData  <= '0;
      pendValid <= 1'b0;
    end else if (strobes.finish) begin
      if (cfgWrEn)        cfgReg <= wrMasked;
      else if (pendValid) cfgReg <= pendData;
      pendValid <= 1'b0;
    end else if (cfgWrEn) begin
      if (strobes.busy) begin
        pendData  <= wrMasked;
        pendValid <= 1'b1;
      end else begin
        cfgReg <= wrMasked;
      end
    end
  end

  // Open row and last-access history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowOpen   <= 1'b0;
      openRow   <= '0;
      openSpace <= '0;
      lastSpace <= '0;
      lastWrite <= 1'b0;
    end else begin
      if (strobes.missTake) begin
        rowOpen   <= 1'b0;
        openRow   <= reqRow;
        openSpace <= reqSpace;
      end else if (strobes.rowUp) begin
        rowOpen <= 1'b1;
      end
      if (strobes.take) begin
        lastSpace <= reqSpace;
        lastWrite <= reqWrite;
      end
    end
  end

  assign isDram   = (reqSpace == SPACE_A) || (reqSpace == SPACE_B);
  assign rowHit   = rowOpen && (openSpace == reqSpace) && (openRow == reqRow);
  assign idleNeed = cfgReg[IDLE_BIT] &&
                    ((lastSpace != reqSpace) || (!lastWrite && reqWrite));
  assign waitEff  = edoMode ? '0 : cfgReg[WAIT_LSB +: WAIT_W];
  assign wideEff  = edoMode ? 1'b0 : cfgReg[WIDE_BIT];

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && $past(strobes.busy)) |-> $stable(cfgReg));

  // R10
  low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn) |-> (cfgRdData[2:0] == 3'b000));

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              isDram,
  input  logic              rowHit,
  input  logic              idleNeed,
  input  logic [WAIT_W-1:0] waitEff,
  input  logic              wideEff,
  input  logic              rowOpen,
  input  logic              edoMode,
  output seqStrobe_t        strobes,
  output logic              reqReady,
  output logic              casN,
  output logic              weN,
  output logic              doneP
);

  seqState_t         state;
  logic [WAIT_W-1:0] cnt;
  logic              curWrite;
  logic              doneQ;
  logic              accept;
  logic              casLast;

  function automatic logic [WAIT_W-1:0] casLoad(input logic wr);
    return wr ? {{(WAIT_W-1){1'b0}}, wideEff} : waitEff;
  endfunction

  assign reqReady = (state == ST_IDLE) && !doneQ;
  assign accept   = reqValid && reqReady;
  assign casLast  = (state == ST_CAS) && (cnt == '0);

  always_comb begin
    strobes.take     = accept;
    strobes.missTake = accept && isDram && !rowHit;
    strobes.rowUp    = (state == ST_PRE);
    strobes.finish   = casLast || (state == ST_FOR);
    strobes.busy     = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      curWrite <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= strobes.finish;
      unique case (state)
        ST_IDLE: if (accept) begin
          curWrite <= reqWrite;
          if (!isDram) state <= ST_FOR;
          else if (!rowHit) state <= ST_PRE;
          else if (idleNeed) state <= ST_GAP;
          else begin
            state <= ST_CAS;
            cnt   <= casLoad(reqWrite);
          end
        end
        ST_PRE: state <= ST_RCD;
        ST_RCD, ST_GAP: begin
          state <= ST_CAS;
          cnt   <= casLoad(curWrite);
        end
        ST_CAS: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_FOR: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign casN  = !(state == ST_CAS);
  assign weN   = !((state == ST_CAS) && curWrite);
  assign doneP = doneQ;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  // R9
  done_after_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casN) |-> doneP);

  // R5
  precharge_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rowOpen) |-> $past(!rowOpen) && casN);

  // R6
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> rowOpen);

  // R4
  edo_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edoMode && $fell(casN)) |=> casN);

endmodule

// File: rtl/dram_wait_seq.sv
module dram_wait_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int SPACE_W = 3,
  parameter int WAIT_W  = 4,
  parameter int DRAM_A  = 4,
  parameter int DRAM_B  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [WAIT_W+4:0]  cfgWrData,
  output logic [WAIT_W+4:0]  cfgRdData,
  input  logic               edoMode,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [SPACE_W-1:0] reqSpace,
  input  logic [ROW_W-1:0]   reqRow,
  output logic               reqReady,
  output logic               rasN,
  output logic               casN,
  output logic               weN,
  output logic               doneP
);

  seqStrobe_t        strobes;
  logic              isDram;
  logic              rowHit;
  logic              idleNeed;
  logic [WAIT_W-1:0] waitEff;
  logic              wideEff;
  logic              rowOpen;

  dram_seq_dp #(
    .ROW_W(ROW_W), .SPACE_W(SPACE_W), .WAIT_W(WAIT_W),
    .DRAM_A(DRAM_A), .DRAM_B(DRAM_B)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .edoMode(edoMode), .reqWrite(reqWrite), .reqSpace(reqSpace), .reqRow(reqRow),
    .strobes(strobes), .isDram(isDram), .rowHit(rowHit), .idleNeed(idleNeed),
    .waitEff(waitEff), .wideEff(wideEff), .rowOpen(rowOpen)
  );

  dram_seq_ctrl #(.WAIT_W(WAIT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .isDram(isDram), .rowHit(rowHit), .idleNeed(idleNeed),
    .waitEff(waitEff), .wideEff(wideEff), .rowOpen(rowOpen), .edoMode(edoMode),
    .strobes(strobes), .reqReady(reqReady),
    .casN(casN), .weN(weN), .doneP(doneP)
  );

  assign rasN = !rowOpen;

endmodule

// File: tb/sim_dram_wait_seq.sv
`timescale 1ns/1ps
module sim_dram_wait_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [8:0] cfgWrData = '0;
  logic [8:0] cfgRdData;
  logic       edoMode = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic [2:0] reqSpace = '0;
  logic [7:0] reqRow = '0;
  logic       reqReady, rasN, casN, weN, doneP;

  int nChecks = 0;
  int nFails  = 0;
  bit ended   = 1'b0;

  always #2.5 clk = ~clk;

  dram_wait_seq u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .edoMode(edoMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqSpace(reqSpace), .reqRow(reqRow),
    .reqReady(reqReady), .rasN(rasN), .casN(casN), .weN(weN), .doneP(doneP)
  );

  typedef struct packed {
    logic [8:0] cfg;
    logic       edo;
    logic       wr;
    logic [2:0] sp;
    logic [7:0] row;
    logic       pre;
    logic [1:0] gap;
    logic [4:0] cas;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{9'h040, 1'b0, 1'b0, 3'd4, 8'h10, 1'b1, 2'd2, 5'd3},   // R5 R2 miss from reset
    '{9'h040, 1'b0, 1'b0, 3'd4, 8'h10, 1'b0, 2'd0, 5'd3},   // R6 hit read
    '{9'h048, 1'b0, 1'b1, 3'd4, 8'h10, 1'b0, 2'd0, 5'd2},   // R3 wide write, idle off
    '{9'h050, 1'b0, 1'b0, 3'd4, 8'h10, 1'b0, 2'd0, 5'd3},   // R7 write->read no idle
    '{9'h050, 1'b0, 1'b1, 3'd4, 8'h10, 1'b0, 2'd1, 5'd1},   // R7 read->write idle
    '{9'h050, 1'b0, 1'b0, 3'd2, 8'h10, 1'b0, 2'd1, 5'd0},   // R8 non-DRAM
    '{9'h050, 1'b0, 1'b0, 3'd4, 8'h10, 1'b0, 2'd1, 5'd3},   // R7 space switch idle
    '{9'h050, 1'b0, 1'b0, 3'd5, 8'h10, 1'b1, 2'd2, 5'd3},   // R5 other DRAM space
    '{9'h050, 1'b0, 1'b1, 3'd5, 8'h22, 1'b1, 2'd2, 5'd1},   // R5 R3 new row write
    '{9'h1E8, 1'b1, 1'b0, 3'd5, 8'h22, 1'b0, 2'd0, 5'd1},   // R4 edo read
    '{9'h1E8, 1'b1, 1'b1, 3'd5, 8'h22, 1'b0, 2'd0, 5'd1},   // R4 edo write
    '{9'h000, 1'b0, 1'b0, 3'd4, 8'h05, 1'b1, 2'd2, 5'd1},   // R2 zero waits
    '{9'h1E0, 1'b0, 1'b0, 3'd4, 8'h05, 1'b0, 2'd0, 5'd16},  // R2 max waits
    '{9'h010, 1'b0, 1'b1, 3'd5, 8'h33, 1'b1, 2'd2, 5'd1}    // R7 miss gets no idle
  };

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitReady();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [8:0] val);
    waitReady();
    cfgWrEn = 1'b1;
    cfgWrData = val;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Issues one access and measures it at the pins.
  task automatic runAccess(input logic wr, input logic [2:0] sp, input logic [7:0] row,
                           output int gap, output int cas, output int pre, output int we);
    gap = 0; cas = 0; pre = 0; we = 0;
    waitReady();
    reqValid = 1'b1; reqWrite = wr; reqSpace = sp; reqRow = row;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (doneP) break;
      if (!casN) cas++;
      else if (cas == 0) gap++;
      if (rasN) pre = 1;
      if (!weN) we = 1;
      @(negedge clk);
    end
    checkEq("R9 done seen", doneP, 1);
    checkEq("R9 ready low in done cycle", reqReady, 0);
    @(negedge clk);
    checkEq("R9 done one cycle", doneP, 0);
  endtask

  initial begin
    int gap, cas, pre, we;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 rasN", rasN, 1);
    checkEq("R1 casN", casN, 1);
    checkEq("R1 weN", weN, 1);
    checkEq("R1 doneP", doneP, 0);
    checkEq("R1 reqReady", reqReady, 1);
    checkEq("R1 cfgRdData", cfgRdData, 9'h1E0);

    for (int v = 0; v < NV; v++) begin
      edoMode = VECS[v].edo;
      cfgWrite(VECS[v].cfg);
      runAccess(VECS[v].wr, VECS[v].sp, VECS[v].row, gap, cas, pre, we);
      checkEq($sformatf("R5/R6/R7/R8 vec%0d gap", v), gap, VECS[v].gap);
      checkEq($sformatf("R2/R3/R4 vec%0d cas length", v), cas, VECS[v].cas);
      checkEq($sformatf("R5/R6 vec%0d precharge", v), pre, VECS[v].pre);
      checkEq($sformatf("R2/R3 vec%0d write enable", v), we, VECS[v].wr);
    end
    edoMode = 1'b0;

    // R11 deferred configuration write
    cfgWrite(9'h060);
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b0; reqSpace = 3'd4; reqRow = 8'h40;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cfgWrEn = 1'b1;
    cfgWrData = 9'h020;
    cas = 0;
    for (int i = 0; i < 40; i++) begin
      if (doneP) break;
      if (!casN) cas++;
      if (i == 1) checkEq("R11 cfg unchanged while busy", cfgRdData, 9'h060);
      @(negedge clk);
      cfgWrEn = 1'b0;
    end
    checkEq("R11 access keeps old waits", cas, 4);
    checkEq("R11 new cfg visible in done cycle", cfgRdData, 9'h020);
    runAccess(1'b0, 3'd4, 8'h40, gap, cas, pre, we);
    checkEq("R11 next access uses new waits", cas, 2);
    checkEq("R6 hit gap", gap, 0);

    // R10 low bits ignore writes
    cfgWrite(9'h1FF);
    checkEq("R10 low bits read zero", cfgRdData, 9'h1F8);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule